// File: doc/BRIEF.md
# Randomized Measurement Basis Sequencer

This block picks, one slot at a time, which quadrature a vacuum-noise homodyne detector measures. Most slots use the data quadrature; about one slot in ten uses the check quadrature, and the choice must not be predictable. Each choice comes from random bits that the system's own extractor output feeds back. For every slot the block drives a DAC code that sets the phase-modulator drive. It also produces a per-sample tag that marks the matching ADC sample as data or check, and it keeps per-frame counts of check slots and total slots.

A run starts when a seed word is loaded. Bit 0 of that seed sets the basis of the first slot, and the whole word initialises a fallback generator. After the first slot, the basis at each boundary comes from a 4-bit draw built from fed-back bits. Values from 10 to 15 are rejected, a value of 0 selects the check basis, and values from 1 to 9 select the data basis. If no accepted draw is waiting at a boundary, the block takes the draw from its internal LFSR and flags that slot. The tag is delayed by a programmable latency so that it lines up with the ADC pipeline.

The controller has four named states. `ST_IDLE` is the state after reset: no run is active and the drive is zero. `ST_SEEDED` is the first slot, whose basis comes from the seed. `ST_FEED` is a slot whose basis came from a fed-back draw. `ST_FALLBACK` is a slot whose basis came from the LFSR. The transitions are as follows. A seed load moves any state to `ST_SEEDED`. At a slot boundary, any state other than `ST_IDLE` moves to `ST_FEED` if a draw is waiting, and to `ST_FALLBACK` if none is. Between boundaries the state does not change.

Top module: `basis_sequencer`

## Requirements
- R1: After reset, and until the first seed load, `dac_code`, `check_basis`, `sample_tag`, `fallback_active`, `frame_checks`, `frame_slots` and `frame_done` are all 0.
- R2: A seed load sampled at a clock edge starts a new slot at that edge. From then on `check_basis` equals `seed_word[0]` (1 means check). The rule applies in every state, including during a run.
- R3: A slot lasts `SLOT_CYCLES` clock cycles, with the default `CLK_HZ/SWITCH_HZ` (a 250 kHz switch rate). `check_basis` changes only at a seed load or at a slot boundary.
- R4: Fed-back bits with `fb_valid` high are shifted in MSB first, four to a draw. A draw value of 10 to 15 is discarded. A value of 0 selects check for the next slot, and a value of 1 to 9 selects data.
- R5: At most one accepted draw waits at a time, and the next boundary consumes it. Fed-back bits offered while a draw is waiting are ignored.
- R6: If no draw is waiting at a boundary, the LFSR is stepped once and its new low nibble v is used. The LFSR is a right-shifting Galois LFSR with toggle mask 0xB400, loaded with `seed_word`, where 0 is replaced by 1. If v is 10 or more, v-6 is used instead. A result of 0 selects check. `fallback_active` is 1 for exactly the slots chosen this way.
- R7: `dac_code` is `HALFWAVE_CODE/2` (a 90° shift) while `check_basis` is 1, and 0 otherwise. Both change on the same edge.
- R8: `sample_tag` equals `check_basis` delayed by `tag_lat` cycles. A value of 0 means no delay, and values above `MAX_LAT` are treated as `MAX_LAT`.
- R9: A `frame_start` sampled at an edge copies the running check and slot counts to `frame_checks` and `frame_slots`, and pulses `frame_done` for one cycle. It then restarts the counts. A slot that starts at the same edge is counted in the new frame.
- R10: The running counts saturate at 2^`CNT_W`-1, and `frame_checks` never exceeds `frame_slots`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the seed and start a run with a new slot |
| seed_word | input | SEED_W | Preloaded seed; bit 0 sets the first basis |
| fb_valid | input | 1 | A fed-back random bit is present |
| fb_bit | input | 1 | Fed-back random bit from the extractor output |
| frame_start | input | 1 | Frame boundary pulse |
| tag_lat | input | LAT_W | Tag delay in cycles to match the ADC pipeline |
| dac_code | output | DAC_W | Phase-modulator drive code |
| check_basis | output | 1 | Current slot is a check slot |
| sample_tag | output | 1 | Delayed basis tag for the matching ADC sample |
| fallback_active | output | 1 | Current slot's basis came from the LFSR |
| frame_checks | output | CNT_W | Check slots in the last completed frame |
| frame_slots | output | CNT_W | Total slots in the last completed frame |
| frame_done | output | 1 | One-cycle pulse when the frame counts update |

## Verification
The hardest case to reach from the ports is a draw that is already waiting when more fed-back bits arrive. The ignored bits leave no direct trace. To expose them, the stimulus feeds an accepted data draw and then a nibble that would select check, all in the same slot. It then supplies nothing in the following slot. If the extra nibble had been kept, that slot would come out as a fed-back check. Instead it must come from the LFSR, with the fallback flag raised, so the ignored bits show up at the ports. The LFSR path is reached in the same way, by leaving slots without feedback or by feeding only rejected values, and the bench predicts the resulting basis from the seed.

// File: rtl/qbs_pkg.sv
package qbs_pkg;

    localparam int DRAW_W     = 4;
    localparam int DRAW_LIMIT = 10;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEEDED   = 2'd1,
        ST_FEED     = 2'd2,
        ST_FALLBACK = 2'd3
    } seq_state_e;

    // Map a raw nibble into 0..9 without rejection (used by the fallback path).
    function automatic logic [DRAW_W-1:0] fold_nibble(input logic [DRAW_W-1:0] v);
        if (v >= DRAW_W'(DRAW_LIMIT))
            return v - DRAW_W'(16 - DRAW_LIMIT);
        return v;
    endfunction

endpackage

// File: rtl/qbs_draw_collect.sv
module qbs_draw_collect
    import qbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fb_valid,
    input  logic fb_bit,
    input  logic consume,
    output logic draw_ready,
    output logic draw_is_zero
);

    localparam int NB_W = $clog2(DRAW_W);

    logic [DRAW_W-2:0] shreg_q;
    logic [NB_W-1:0]   nbits_q;
    logic              ready_q;
    logic              zero_q;
    logic [DRAW_W-1:0] full_draw;

    assign full_draw = {shreg_q, fb_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            nbits_q <= '0;
            ready_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (clear) begin
            shreg_q <= '0;
            nbits_q <= '0;
            ready_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            if (consume)
                ready_q <= 1'b0;
            if (fb_valid && !ready_q) begin
                if (nbits_q == NB_W'(DRAW_W - 1)) begin
                    nbits_q <= '0;
                    if (full_draw < DRAW_W'(DRAW_LIMIT)) begin
                        ready_q <= 1'b1;
                        zero_q  <= (full_draw == '0);
                    end
                end else begin
                    shreg_q <= {shreg_q[DRAW_W-3:0], fb_bit};
                    nbits_q <= nbits_q + NB_W'(1);
                end
            end
        end
    end

    assign draw_ready   = ready_q;
    assign draw_is_zero = zero_q;

endmodule

// File: rtl/qbs_lfsr.sv
module qbs_lfsr #(
    parameter int               SEED_W = 16,
    parameter logic [SEED_W-1:0] TAPS  = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEED_W-1:0] seed,
    input  logic              step,
    output logic [SEED_W-1:0] nxt
);

    logic [SEED_W-1:0] state_q;

    always_comb begin
        nxt = state_q >> 1;
        if (state_q[0])
            nxt = nxt ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEED_W'(1);
        else if (load)
            state_q <= (seed == '0) ? SEED_W'(1) : seed;
        else if (step)
            state_q <= nxt;
    end

endmodule

// File: rtl/qbs_tag_delay.sv
module qbs_tag_delay #(
    parameter int MAX_LAT = 15,
    parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_in,
    input  logic [LAT_W-1:0] lat,
    output logic             tag_out
);

    logic [LAT_W-1:0] lat_eff;
    assign lat_eff = (lat > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat;

    generate
        if (MAX_LAT == 0) begin : g_none
            assign tag_out = tag_in;
        end else if (MAX_LAT == 1) begin : g_single
            logic hist_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= 1'b0;
                else        hist_q <= tag_in;
            end
            assign tag_out = (lat_eff == '0) ? tag_in : hist_q;
        end else begin : g_line
            logic [MAX_LAT-1:0] hist_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[MAX_LAT-2:0], tag_in};
            end
            assign tag_out = (lat_eff == '0) ? tag_in : hist_q[lat_eff - LAT_W'(1)];
        end
    endgenerate

endmodule

// File: rtl/qbs_frame_count.sv
module qbs_frame_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic             slot_check,
    input  logic             frame_start,
    output logic [CNT_W-1:0] frame_checks,
    output logic [CNT_W-1:0] frame_slots,
    output logic             frame_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_slots_q, run_checks_q;
    logic [CNT_W-1:0] snap_slots_q, snap_checks_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_slots_q   <= '0;
            run_checks_q  <= '0;
            snap_slots_q  <= '0;
            snap_checks_q <= '0;
            done_q        <= 1'b0;
        end else begin
            done_q <= frame_start;
            if (frame_start) begin
                snap_slots_q  <= run_slots_q;
                snap_checks_q <= run_checks_q;
                run_slots_q   <= CNT_W'(slot_start);
                run_checks_q  <= CNT_W'(slot_start && slot_check);
            end else if (slot_start) begin
                if (run_slots_q != CNT_MAX)
                    run_slots_q <= run_slots_q + CNT_W'(1);
                if (slot_check && run_checks_q != CNT_MAX)
                    run_checks_q <= run_checks_q + CNT_W'(1);
            end
        end
    end

    assign frame_checks = snap_checks_q;
    assign frame_slots  = snap_slots_q;
    assign frame_done   = done_q;

endmodule

// File: rtl/basis_sequencer.sv
module basis_sequencer
    import qbs_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int SWITCH_HZ     = 250_000,
    parameter int SLOT_CYCLES   = CLK_HZ / SWITCH_HZ,
    parameter int DAC_W         = 12,
    parameter int HALFWAVE_CODE = 3000,
    parameter int SEED_W        = 16,
    parameter logic [SEED_W-1:0] LFSR_TAPS = 16'hB400,
    parameter int MAX_LAT       = 15,
    parameter int LAT_W         = $clog2(MAX_LAT + 1),
    parameter int CNT_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [SEED_W-1:0] seed_word,
    input  logic              fb_valid,
    input  logic              fb_bit,
    input  logic              frame_start,
    input  logic [LAT_W-1:0]  tag_lat,
    output logic [DAC_W-1:0]  dac_code,
    output logic              check_basis,
    output logic              sample_tag,
    output logic              fallback_active,
    output logic [CNT_W-1:0]  frame_checks,
    output logic [CNT_W-1:0]  frame_slots,
    output logic              frame_done
);

    localparam int              SLOT_CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [SLOT_CNT_W-1:0] SLOT_LAST = SLOT_CNT_W'(SLOT_CYCLES - 1);
    localparam logic [DAC_W-1:0] CHECK_CODE = DAC_W'(HALFWAVE_CODE / 2);

    seq_state_e              state_q, state_d;
    logic [SLOT_CNT_W-1:0]   slot_cnt_q;
    logic                    basis_q, basis_d;
    logic [DAC_W-1:0]        dac_q;

    logic                    boundary;
    logic                    draw_ready, draw_is_zero;
    logic                    consume, lfsr_step;
    logic [SEED_W-1:0]       lfsr_nxt;
    logic                    lfsr_check;
    logic                    slot_start;

    // ---- sub-blocks -------------------------------------------------------
    qbs_draw_collect u_draw (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (seed_load),
        .fb_valid     (fb_valid),
        .fb_bit       (fb_bit),
        .consume      (consume),
        .draw_ready   (draw_ready),
        .draw_is_zero (draw_is_zero)
    );

    qbs_lfsr #(.SEED_W(SEED_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_word),
        .step  (lfsr_step),
        .nxt   (lfsr_nxt)
    );

    assign lfsr_check = (fold_nibble(lfsr_nxt[DRAW_W-1:0]) == '0);

    // ---- slot timing --------------------------------------------------------
    assign boundary   = (state_q != ST_IDLE) && (slot_cnt_q == SLOT_LAST);
    assign consume    = boundary && draw_ready && !seed_load;
    assign lfsr_step  = boundary && !draw_ready && !seed_load;
    assign slot_start = seed_load || boundary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_cnt_q <= '0;
        else if (slot_start || state_q == ST_IDLE)
            slot_cnt_q <= '0;
        else
            slot_cnt_q <= slot_cnt_q + SLOT_CNT_W'(1);
    end

    // ---- next-state and next-basis logic -------------------------------------
    always_comb begin
        state_d = state_q;
        basis_d = basis_q;
        unique case (state_q)
            ST_IDLE: begin
                if (seed_load) begin
                    state_d = ST_SEEDED;
                    basis_d = seed_word[0];
                end
            end
            ST_SEEDED, ST_FEED, ST_FALLBACK: begin
                if (seed_load) begin
                    state_d = ST_SEEDED;
                    basis_d = seed_word[0];
                end else if (boundary && draw_ready) begin
                    state_d = ST_FEED;
                    basis_d = draw_is_zero;
                end else if (boundary) begin
                    state_d = ST_FALLBACK;
                    basis_d = lfsr_check;
                end
            end
            default: begin
                state_d = ST_IDLE;
                basis_d = 1'b0;
            end
        endcase
    end

    // ---- state register ------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---- output registers ----------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            basis_q <= 1'b0;
            dac_q   <= '0;
        end else begin
            basis_q <= basis_d;
            dac_q   <= basis_d ? CHECK_CODE : '0;
        end
    end

    assign check_basis     = basis_q;
    assign dac_code        = dac_q;
    assign fallback_active = (state_q == ST_FALLBACK);

    qbs_tag_delay #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_in  (basis_q),
        .lat     (tag_lat),
        .tag_out (sample_tag)
    );

    qbs_frame_count #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_start   (slot_start),
        .slot_check   (basis_d),
        .frame_start  (frame_start),
        .frame_checks (frame_checks),
        .frame_slots  (frame_slots),
        .frame_done   (frame_done)
    );

endmodule

// File: rtl/qbs_checker.sv
module qbs_checker #(
    parameter int SLOT_CYCLES   = 200,
    parameter int DAC_W         = 12,
    parameter int HALFWAVE_CODE = 3000,
    parameter int SEED_W        = 16,
    parameter int LAT_W         = 4,
    parameter int CNT_W         = 16,
    parameter int SLOT_CNT_W    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  seed_load,
    input logic [SEED_W-1:0]     seed_word,
    input logic                  frame_start,
    input logic [LAT_W-1:0]      tag_lat,
    input logic [DAC_W-1:0]      dac_code,
    input logic                  check_basis,
    input logic                  sample_tag,
    input logic                  fallback_active,
    input logic [CNT_W-1:0]      frame_checks,
    input logic [CNT_W-1:0]      frame_slots,
    input logic                  frame_done,
    input logic [1:0]            state_q,
    input logic [SLOT_CNT_W-1:0] slot_cnt_q
);

    localparam logic [DAC_W-1:0]      CHECK_CODE = DAC_W'(HALFWAVE_CODE / 2);
    localparam logic [SLOT_CNT_W-1:0] SLOT_LAST  = SLOT_CNT_W'(SLOT_CYCLES - 1);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd0) |-> (!fallback_active && dac_code == '0 && !check_basis)) // R1
        else $error("idle outputs not quiet");

    AST_SEED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (check_basis == $past(seed_word[0]))) // R2
        else $error("first slot basis differs from seed bit");

    AST_BASIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && (state_q == 2'd0 || slot_cnt_q != SLOT_LAST)) |=> $stable(check_basis)) // R3
        else $error("basis changed inside a slot");

    AST_DAC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code == (check_basis ? CHECK_CODE : '0)) // R7
        else $error("drive code does not follow basis");

    AST_TAG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_lat == LAT_W'(1) && $past(tag_lat) == LAT_W'(1)) |-> (sample_tag == $past(check_basis))) // R8
        else $error("tag not one cycle behind basis");

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_done) // R9
        else $error("missing frame pulse");

    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> !frame_done) // R9
        else $error("spurious frame pulse");

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_checks <= frame_slots) // R10
        else $error("check count exceeds slot count");

endmodule

bind basis_sequencer qbs_checker #(
    .SLOT_CYCLES   (SLOT_CYCLES),
    .DAC_W         (DAC_W),
    .HALFWAVE_CODE (HALFWAVE_CODE),
    .SEED_W        (SEED_W),
    .LAT_W         (LAT_W),
    .CNT_W         (CNT_W),
    .SLOT_CNT_W    (SLOT_CNT_W)
) u_qbs_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .seed_load       (seed_load),
    .seed_word       (seed_word),
    .frame_start     (frame_start),
    .tag_lat         (tag_lat),
    .dac_code        (dac_code),
    .check_basis     (check_basis),
    .sample_tag      (sample_tag),
    .fallback_active (fallback_active),
    .frame_checks    (frame_checks),
    .frame_slots     (frame_slots),
    .frame_done      (frame_done),
    .state_q         (state_q),
    .slot_cnt_q      (slot_cnt_q)
);

// File: tb/test_basis_sequencer.sv
module test_basis_sequencer;

    localparam int N      = 20;
    localparam int DAC_W  = 12;
    localparam int HWAVE  = 3000;
    localparam int CNT_W  = 4;
    localparam int LAT_W  = 4;
    localparam int CHK    = HWAVE / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              seed_load = 1'b0;
    logic [15:0]       seed_word = '0;
    logic              fb_valid = 1'b0;
    logic              fb_bit = 1'b0;
    logic              frame_start = 1'b0;
    logic [LAT_W-1:0]  tag_lat = '0;
    logic [DAC_W-1:0]  dac_code;
    logic              check_basis;
    logic              sample_tag;
    logic              fallback_active;
    logic [CNT_W-1:0]  frame_checks;
    logic [CNT_W-1:0]  frame_slots;
    logic              frame_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    basis_sequencer #(
        .SLOT_CYCLES(N), .DAC_W(DAC_W), .HALFWAVE_CODE(HWAVE),
        .MAX_LAT(15), .LAT_W(LAT_W), .CNT_W(CNT_W)
    ) i_basis_sequencer (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_word(seed_word),
        .fb_valid(fb_valid), .fb_bit(fb_bit), .frame_start(frame_start),
        .tag_lat(tag_lat), .dac_code(dac_code), .check_basis(check_basis),
        .sample_tag(sample_tag), .fallback_active(fallback_active),
        .frame_checks(frame_checks), .frame_slots(frame_slots),
        .frame_done(frame_done)
    );

    // Vector: {mode[1:0], nib_a[3:0], nib_b[3:0], exp_check, exp_fallback}
    // mode 0: no bits, 1: nib_a, 2: nib_a then nib_b, 3: nib_a then nib_b while pending.
    // Fallback expectations follow the LFSR from seed 0xACE1: nibbles 0, 8, C(->6), E(->8).
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {2'd1, 4'd0,  4'd0,  1'b1, 1'b0},  // R4 zero -> check
        {2'd1, 4'd5,  4'd0,  1'b0, 1'b0},  // R4 data
        {2'd1, 4'd9,  4'd0,  1'b0, 1'b0},  // R4 top accepted value
        {2'd2, 4'd12, 4'd0,  1'b1, 1'b0},  // R4 reject 12, take 0
        {2'd2, 4'd15, 4'd3,  1'b0, 1'b0},  // R4 reject 15, take 3
        {2'd0, 4'd0,  4'd0,  1'b1, 1'b1},  // R6 fallback, nibble 0
        {2'd3, 4'd4,  4'd0,  1'b0, 1'b0},  // R5 extra zero ignored
        {2'd0, 4'd0,  4'd0,  1'b0, 1'b1},  // R5 R6 nothing kept -> fallback
        {2'd2, 4'd10, 4'd0,  1'b1, 1'b0},  // R4 reject 10
        {2'd0, 4'd0,  4'd0,  1'b0, 1'b1},  // R6 fallback fold 12 -> 6
        {2'd1, 4'd0,  4'd0,  1'b1, 1'b0},  // R4
        {2'd2, 4'd13, 4'd14, 1'b0, 1'b1},  // R4 R6 both rejected -> fallback
        {2'd1, 4'd1,  4'd0,  1'b0, 1'b0}   // R4
    };

    task automatic check_val(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_slot(input int mode, input logic [3:0] a, input logic [3:0] b);
        logic start_basis;
        start_basis = check_basis;
        for (int i = 0; i < N; i++) begin
            fb_valid = 1'b0;
            fb_bit   = 1'b0;
            if (i < 4 && mode >= 1) begin
                fb_valid = 1'b1;
                fb_bit   = a[3-i];
            end else if (i >= 4 && i < 8 && mode >= 2) begin
                fb_valid = 1'b1;
                fb_bit   = b[7-i];
            end
            if (i == N/2)
                check_val("R3 basis stable mid-slot", int'(check_basis), int'(start_basis));
            @(negedge clk);
        end
        fb_valid = 1'b0;
    endtask

    task automatic pulse_seed(input logic [15:0] s, input logic with_frame);
        seed_word   = s;
        seed_load   = 1'b1;
        frame_start = with_frame;
        @(negedge clk);
        seed_load   = 1'b0;
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check_val("R1 dac in reset", int'(dac_code), 0);
        check_val("R1 basis in reset", int'(check_basis), 0);
        check_val("R1 tag in reset", int'(sample_tag), 0);
        check_val("R1 fallback in reset", int'(fallback_active), 0);
        check_val("R1 slots in reset", int'(frame_slots), 0);
        check_val("R1 done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        repeat (N + 3) @(negedge clk);
        check_val("R1 idle basis", int'(check_basis), 0);
        check_val("R1 idle fallback", int'(fallback_active), 0);

        // R2 first slot from seed bit 0 (0xACE1 -> check); frame opened at same edge (R9)
        pulse_seed(16'hACE1, 1'b1);
        check_val("R2 seeded basis", int'(check_basis), 1);
        check_val("R7 check drive", int'(dac_code), CHK);
        check_val("R2 seeded not fallback", int'(fallback_active), 0);

        for (int v = 0; v < NV; v++) begin
            string req;
            int    mode;
            mode = int'(VEC[v][11:10]);
            req  = (mode == 0) ? "R6" : (mode == 3) ? "R5" : "R4";
            run_slot(mode, VEC[v][9:6], VEC[v][5:2]);
            check_val({req, " basis"}, int'(check_basis), int'(VEC[v][1]));
            check_val("R7 drive code", int'(dac_code), VEC[v][1] ? CHK : 0);
            check_val("R6 fallback flag", int'(fallback_active), int'(VEC[v][0]));
        end

        // R9: 14 slots, 6 of them check
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check_val("R9 frame pulse", int'(frame_done), 1);
        check_val("R9 frame slots", int'(frame_slots), 14);
        check_val("R9 frame checks", int'(frame_checks), 6);
        @(negedge clk);
        check_val("R9 pulse one cycle", int'(frame_done), 0);

        // R10: more than 15 slots in a frame saturates
        repeat (N * 18) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check_val("R10 saturated slots", int'(frame_slots), 15);
        check_val("R10 checks bounded", int'(frame_checks <= frame_slots), 1);

        // R8: tag delay of 3 across a data->check reseed (R2 mid-run)
        tag_lat = 4'd3;
        pulse_seed(16'h0002, 1'b0);
        check_val("R2 reseed data", int'(check_basis), 0);
        repeat (6) @(negedge clk);
        pulse_seed(16'h0001, 1'b0);
        check_val("R2 reseed check", int'(check_basis), 1);
        check_val("R8 tag lag 0", int'(sample_tag), 0);
        @(negedge clk);
        @(negedge clk);
        check_val("R8 tag lag 2", int'(sample_tag), 0);
        @(negedge clk);
        check_val("R8 tag lag 3", int'(sample_tag), 1);
        tag_lat = 4'd0;
        #1;
        check_val("R8 tag no delay", int'(sample_tag), int'(check_basis));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule